// File: doc/BRIEF.md
# Processor Flag Register and Interrupt Gate

This block keeps the five status flags of a small 8-bit processor core: half carry (H), interrupt mask (I), negative (N), zero (Z) and carry (C). Each cycle in which the execute stage presents a result, the block folds that result into the flags. The update follows an operation-class code that tells it which flags the operation may change. The same block owns the interrupt mask. It holds back interrupt requests while the mask is set and remembers a request that came in during that time. It raises a take request to the sequencer once servicing is allowed.

The interrupt sequencer and the instruction decoder drive plain one-cycle strobes: start of interrupt entry, end of register stacking, return-from-interrupt restore, and the three mask-clearing instructions. The flags read back as a byte whose upper three bits are always one. The ALU, the stack memory and the decoder sit outside. All pins are plain control and status signals, with no valid/ready handshake. Every strobe is accepted in the cycle it is high, and nothing can stall the block.

Top module: `ccr_unit`

## Requirements
- R1: `ccr_rd` is {3'b111, H, I, N, Z, C}: bit 4 is H, bit 3 is I, bit 2 is N, bit 1 is Z, bit 0 is C, and bits 7..5 are always 1.
- R2: While `rst_n` is low, I is forced to 1 and `irq_take` is 0. H, N, Z and C keep the values they held before reset.
- R3: On an accepted update with class 0 (add/add-with-carry), H takes `alu_half` on the next edge. Every other class leaves H unchanged.
- R4: On an accepted update with class 0, 1 (other arithmetic), 2 (shift/rotate), 3 (logical) or 4 (load/data move), N takes bit 7 of `alu_result`. Z is 1 exactly when `alu_result` is zero. Classes 5 to 7 change no flag.
- R5: On an accepted update, C takes `alu_carry` for classes 0, 1 and 2. Classes 3 and 4 leave C unchanged.
- R6: `irq_take` is 1 only while I is 0. In that state it is 1 whenever `irq_req` is high in the same cycle.
- R7: A request seen on `irq_req` while I is 1 is latched as pending. Once I is 0, `irq_take` stays 1 even with `irq_req` low. `entry_start` clears the pending latch.
- R8: `stack_done` sets I to 1 on the next edge. This also holds when a clear strobe arrives in the same cycle.
- R9: `restore` loads H, I, N, Z and C from `restore_val[4:0]` (same bit positions as R1) on the next edge. It takes priority over an update, `stack_done` and the clear strobes in the same cycle.
- R10: Apart from R9, I goes from 1 to 0 only on `clr_cli`, `clr_stop` or `clr_wait`. Updates of any class, `entry_start` and `irq_req` never clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; affects only I and the pending latch |
| upd_valid | input | 1 | Apply an ALU result to the flags this cycle |
| op_class | input | 3 | Operation class of the result (see R3 to R5) |
| alu_result | input | 8 | ALU result byte |
| alu_carry | input | 1 | Carry or borrow out of the ALU |
| alu_half | input | 1 | Carry from bit 3 into bit 4 |
| irq_req | input | 1 | Combined internal/external interrupt request level |
| entry_start | input | 1 | Interrupt entry sequence begins |
| stack_done | input | 1 | Register stacking finished, vector fetch next |
| restore | input | 1 | Return-from-interrupt flag restore |
| restore_val | input | 8 | Flag byte pulled from the stack |
| clr_cli | input | 1 | Clear-mask instruction strobe |
| clr_stop | input | 1 | Stop instruction strobe (clears mask) |
| clr_wait | input | 1 | Wait instruction strobe (clears mask) |
| ccr_rd | output | 8 | Flag byte read value |
| flag_h | output | 1 | Half carry |
| flag_i | output | 1 | Interrupt mask |
| flag_n | output | 1 | Negative |
| flag_z | output | 1 | Zero |
| flag_c | output | 1 | Carry |
| irq_take | output | 1 | Interrupt may be taken now |

## Verification
The hardest case to reach from the ports is a request that was only latched. That request has to be told apart from a live one, and so does its cancellation. The stimulus masks interrupts, raises `irq_req` for a single cycle and drops it, and then clears the mask through a strobe. With the request line low, `irq_take` can only come from the latch. An `entry_start` pulse follows, then a second mask and unmask cycle, which shows that the latch has been emptied. Flag rules are swept over every class, every result byte and every carry/half-carry pair. A restore is tried with every byte value while conflicting strobes are active.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

  typedef enum logic [2:0] {
    OPC_ADD   = 3'd0,
    OPC_ARITH = 3'd1,
    OPC_SHIFT = 3'd2,
    OPC_LOGIC = 3'd3,
    OPC_LOAD  = 3'd4,
    OPC_RSV5  = 3'd5,
    OPC_RSV6  = 3'd6,
    OPC_RSV7  = 3'd7
  } opc_e;

  localparam int CCR_W   = 8;
  localparam int LIVE_W  = 5;
  localparam int BIT_C   = 0;
  localparam int BIT_Z   = 1;
  localparam int BIT_N   = 2;
  localparam int BIT_I   = 3;
  localparam int BIT_H   = 4;

  typedef struct packed {
    logic h;
    logic n;
    logic z;
    logic c;
  } alu_flags_t;

endpackage

// File: rtl/ccr_flag_calc.sv
module ccr_flag_calc
  import ccr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [2:0]        op_class,
  input  logic [DATA_W-1:0] result,
  input  logic              carry,
  input  logic              half,
  input  alu_flags_t        cur,
  output alu_flags_t        nxt
);

  logic res_neg;
  logic res_zero;

  assign res_neg  = result[DATA_W-1];
  assign res_zero = (result == '0);

  always_comb begin
    nxt = cur;
    case (opc_e'(op_class))
      OPC_ADD: begin
        nxt.h = half;
        nxt.n = res_neg;
        nxt.z = res_zero;
        nxt.c = carry;
      end
      OPC_ARITH, OPC_SHIFT: begin
        nxt.n = res_neg;
        nxt.z = res_zero;
        nxt.c = carry;
      end
      OPC_LOGIC, OPC_LOAD: begin
        nxt.n = res_neg;
        nxt.z = res_zero;
      end
      default: nxt = cur;
    endcase
  end

endmodule

// File: rtl/ccr_mask_ctl.sv
module ccr_mask_ctl #(
  parameter int NUM_CLR = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restore,
  input  logic               restore_i,
  input  logic               stack_done,
  input  logic [NUM_CLR-1:0] clr_vec,
  input  logic               irq_req,
  input  logic               entry_start,
  output logic               mask,
  output logic               take
);

  logic pend_q;
  logic clr_any;

  assign clr_any = |clr_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= 1'b1;
    end else if (restore) begin
      mask <= restore_i;
    end else if (stack_done) begin
      mask <= 1'b1;
    end else if (clr_any) begin
      mask <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (entry_start) begin
      pend_q <= 1'b0;
    end else if (irq_req && mask) begin
      pend_q <= 1'b1;
    end
  end

  assign take = !mask && (irq_req || pend_q);

endmodule

// File: rtl/ccr_unit.sv
module ccr_unit
  import ccr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_valid,
  input  logic [2:0]        op_class,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              alu_carry,
  input  logic              alu_half,
  input  logic              irq_req,
  input  logic              entry_start,
  input  logic              stack_done,
  input  logic              restore,
  input  logic [CCR_W-1:0]  restore_val,
  input  logic              clr_cli,
  input  logic              clr_stop,
  input  logic              clr_wait,
  output logic [CCR_W-1:0]  ccr_rd,
  output logic              flag_h,
  output logic              flag_i,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_c,
  output logic              irq_take
);

  localparam int UPPER_W = CCR_W - LIVE_W;

  alu_flags_t flags_q;
  alu_flags_t flags_nxt;
  alu_flags_t flags_rst;

  assign flags_rst.h = restore_val[BIT_H];
  assign flags_rst.n = restore_val[BIT_N];
  assign flags_rst.z = restore_val[BIT_Z];
  assign flags_rst.c = restore_val[BIT_C];

  ccr_flag_calc #(.DATA_W(DATA_W)) u_calc (
    .op_class (op_class),
    .result   (alu_result),
    .carry    (alu_carry),
    .half     (alu_half),
    .cur      (flags_q),
    .nxt      (flags_nxt)
  );

  // Arithmetic flags carry no reset: only the mask responds to rst_n.
  always_ff @(posedge clk) begin
    if (restore) begin
      flags_q <= flags_rst;
    end else if (upd_valid) begin
      flags_q <= flags_nxt;
    end
  end

  ccr_mask_ctl #(.NUM_CLR(3)) u_mask (
    .clk         (clk),
    .rst_n       (rst_n),
    .restore     (restore),
    .restore_i   (restore_val[BIT_I]),
    .stack_done  (stack_done),
    .clr_vec     ({clr_wait, clr_stop, clr_cli}),
    .irq_req     (irq_req),
    .entry_start (entry_start),
    .mask        (flag_i),
    .take        (irq_take)
  );

  assign flag_h = flags_q.h;
  assign flag_n = flags_q.n;
  assign flag_z = flags_q.z;
  assign flag_c = flags_q.c;

  always_comb begin
    ccr_rd        = '0;
    ccr_rd[CCR_W-1:LIVE_W] = {UPPER_W{1'b1}};
    ccr_rd[BIT_H] = flag_h;
    ccr_rd[BIT_I] = flag_i;
    ccr_rd[BIT_N] = flag_n;
    ccr_rd[BIT_Z] = flag_z;
    ccr_rd[BIT_C] = flag_c;
  end

endmodule

// File: rtl/ccr_unit_chk.sv
module ccr_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       upd_valid,
  input logic [2:0] op_class,
  input logic       alu_carry,
  input logic       alu_half,
  input logic       irq_req,
  input logic       entry_start,
  input logic       stack_done,
  input logic       restore,
  input logic [7:0] restore_val,
  input logic       clr_cli,
  input logic       clr_stop,
  input logic       clr_wait,
  input logic       flag_h,
  input logic       flag_i,
  input logic       flag_n,
  input logic       flag_z,
  input logic       flag_c,
  input logic       irq_take
);

  AST_RESET_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> flag_i); // R2

  AST_HALF_ON_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !restore && op_class == 3'd0) |=> (flag_h == $past(alu_half))); // R3

  AST_HALF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!restore && (!upd_valid || op_class != 3'd0)) |=> $stable(flag_h)); // R3

  AST_CARRY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !restore && (op_class == 3'd3 || op_class == 3'd4)) |=> $stable(flag_c)); // R5

  AST_NO_TAKE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    flag_i |-> !irq_take); // R6

  AST_LIVE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_i && irq_req) |-> irq_take); // R6

  AST_PEND_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq_req && flag_i && !entry_start) && !flag_i && !entry_start) |-> irq_take); // R7

  AST_STACK_SETS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (stack_done && !restore) |=> flag_i); // R8

  AST_RESTORE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    restore |=> ({flag_h, flag_i, flag_n, flag_z, flag_c} == $past(restore_val[4:0]))); // R9

  AST_MASK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_i && !restore && !clr_cli && !clr_stop && !clr_wait) |=> flag_i); // R10

endmodule

bind ccr_unit ccr_unit_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .upd_valid   (upd_valid),
  .op_class    (op_class),
  .alu_carry   (alu_carry),
  .alu_half    (alu_half),
  .irq_req     (irq_req),
  .entry_start (entry_start),
  .stack_done  (stack_done),
  .restore     (restore),
  .restore_val (restore_val),
  .clr_cli     (clr_cli),
  .clr_stop    (clr_stop),
  .clr_wait    (clr_wait),
  .flag_h      (flag_h),
  .flag_i      (flag_i),
  .flag_n      (flag_n),
  .flag_z      (flag_z),
  .flag_c      (flag_c),
  .irq_take    (irq_take)
);

// File: tb/ccr_unit_tb.sv
`timescale 1ns/100ps
module ccr_unit_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       upd_valid = 1'b0;
  logic [2:0] op_class = 3'd0;
  logic [7:0] alu_result = 8'd0;
  logic       alu_carry = 1'b0;
  logic       alu_half = 1'b0;
  logic       irq_req = 1'b0;
  logic       entry_start = 1'b0;
  logic       stack_done = 1'b0;
  logic       restore = 1'b0;
  logic [7:0] restore_val = 8'd0;
  logic       clr_cli = 1'b0;
  logic       clr_stop = 1'b0;
  logic       clr_wait = 1'b0;
  logic [7:0] ccr_rd;
  logic       flag_h, flag_i, flag_n, flag_z, flag_c, irq_take;

  int checks = 0;
  int errors = 0;
  logic mh, mi, mn, mz, mc;

  always #2.5 clk = ~clk;

  ccr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .op_class(op_class),
    .alu_result(alu_result), .alu_carry(alu_carry), .alu_half(alu_half),
    .irq_req(irq_req), .entry_start(entry_start), .stack_done(stack_done),
    .restore(restore), .restore_val(restore_val), .clr_cli(clr_cli),
    .clr_stop(clr_stop), .clr_wait(clr_wait), .ccr_rd(ccr_rd),
    .flag_h(flag_h), .flag_i(flag_i), .flag_n(flag_n), .flag_z(flag_z),
    .flag_c(flag_c), .irq_take(irq_take)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_byte();
    return {3'b111, mh, mi, mn, mz, mc};
  endfunction

  task automatic clear_strobes();
    upd_valid = 0; restore = 0; stack_done = 0; entry_start = 0;
    clr_cli = 0; clr_stop = 0; clr_wait = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R2: reset forces mask, blocks take even with a live request
    irq_req = 1;
    repeat (3) cyc();
    chk("R2 mask in reset", {7'd0, flag_i}, 8'd1);
    chk("R2 no take in reset", {7'd0, irq_take}, 8'd0);
    chk("R1 upper bits", {5'd0, ccr_rd[7:5]}, 8'd7);
    irq_req = 0;
    rst_n = 1;
    cyc();
    // establish known flags: add with zero result
    upd_valid = 1; op_class = 3'd0; alu_result = 8'd0; alu_carry = 0; alu_half = 0;
    clr_cli = 1;
    cyc();
    clear_strobes();
    mh = 0; mi = 0; mn = 0; mz = 1; mc = 0;
    chk("R10 cli clears mask", ccr_rd, model_byte());

    // R3 R4 R5: exhaustive sweep of class x result x carry/half
    for (int op = 0; op < 8; op++) begin
      for (int r = 0; r < 256; r++) begin
        for (int ch = 0; ch < 4; ch++) begin
          upd_valid = 1; op_class = op[2:0]; alu_result = r[7:0];
          alu_carry = ch[0]; alu_half = ch[1];
          cyc();
          if (op <= 4) begin
            mn = r[7];
            mz = (r == 0);
          end
          if (op == 0) mh = ch[1];
          if (op <= 2) mc = ch[0];
          chk("R3/R4/R5 flag update", ccr_rd, model_byte());
        end
      end
    end
    upd_valid = 0;
    cyc();

    // R2: flags survive reset, only mask set
    upd_valid = 1; op_class = 3'd0; alu_result = 8'h80; alu_carry = 1; alu_half = 1;
    cyc();
    upd_valid = 0;
    mh = 1; mn = 1; mz = 0; mc = 1;
    rst_n = 0;
    cyc(); cyc();
    mi = 1;
    chk("R2 retain through reset", ccr_rd, model_byte());
    rst_n = 1;
    cyc();

    // R10: mask stays set under non-clearing activity
    entry_start = 1; irq_req = 1;
    cyc();
    entry_start = 0; irq_req = 0;
    for (int op = 0; op < 8; op++) begin
      upd_valid = 1; op_class = op[2:0]; alu_result = 8'h00; alu_carry = 0; alu_half = 0;
      cyc();
    end
    upd_valid = 0;
    cyc();
    chk("R10 mask sticky", {7'd0, flag_i}, 8'd1);
    chk("R4 zero after load", {7'd0, flag_z}, 8'd1);
    // each clear strobe clears it
    for (int k = 0; k < 3; k++) begin
      stack_done = 1;
      cyc();
      stack_done = 0;
      chk("R8 stack_done sets mask", {7'd0, flag_i}, 8'd1);
      clr_cli = (k == 0); clr_stop = (k == 1); clr_wait = (k == 2);
      cyc();
      clear_strobes();
      chk("R10 clear strobe", {7'd0, flag_i}, 8'd0);
    end
    // R8: stack_done wins over clear
    stack_done = 1; clr_cli = 1;
    cyc();
    clear_strobes();
    chk("R8 stack_done over cli", {7'd0, flag_i}, 8'd1);

    // R6/R7: pending latch
    irq_req = 1;
    cyc();
    chk("R6 masked no take", {7'd0, irq_take}, 8'd0);
    irq_req = 0;
    cyc();
    chk("R6 masked no take after drop", {7'd0, irq_take}, 8'd0);
    clr_cli = 1;
    cyc();
    clear_strobes();
    chk("R7 latched request taken", {7'd0, irq_take}, 8'd1);
    entry_start = 1;
    cyc();
    entry_start = 0;
    chk("R7 take cleared by entry", {7'd0, irq_take}, 8'd0);
    stack_done = 1;
    cyc();
    stack_done = 0;
    clr_cli = 1;
    cyc();
    clear_strobes();
    chk("R7 latch empty after entry", {7'd0, irq_take}, 8'd0);
    irq_req = 1;
    #1;
    chk("R6 live take unmasked", {7'd0, irq_take}, 8'd1);
    cyc();
    irq_req = 0;
    #1;
    chk("R6 live only no latch", {7'd0, irq_take}, 8'd0);
    cyc();

    // R9: restore every byte against conflicting strobes
    for (int v = 0; v < 256; v++) begin
      restore = 1; restore_val = v[7:0];
      upd_valid = 1; op_class = 3'd0; alu_result = ~v[7:0]; alu_carry = ~v[0]; alu_half = ~v[4];
      stack_done = v[5]; clr_cli = v[6]; clr_wait = v[7];
      cyc();
      mh = v[4]; mi = v[3]; mn = v[2]; mz = v[1]; mc = v[0];
      chk("R9 restore", ccr_rd, model_byte());
    end
    clear_strobes();
    cyc();
    chk("R1 read layout", ccr_rd, model_byte());

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule